// File: doc/BRIEF.md
# Prioritised Edge/Level Interrupt Controller

The block collects interrupt request lines in banks of 32 and keeps one pending bit for each line. Each line can be set as edge or level sensitive and carries a mask bit. A control word for each line holds a priority and steers the line to one of two output classes: the normal interrupt (IRQ) or the fast interrupt (FIQ). For each class, an arbiter picks the eligible line with the best priority. The result is latched and reported to the CPU through a sorted-code register, while the class output is driven high.

The CPU reaches the block through a simple 32-bit strobe bus. Bits from 8 upward in the address select the bank and the low byte selects the register. Once a class output has been raised, it stays high and its code stays frozen until software renews the class through the control register. Reading a sorted code acknowledges the reported line if that line is edge sensitive. Level lines drop only when their input falls, or through a pending write while their input is low.

Top module: `irq_ctrl_regs`

## Requirements
- R1: After reset both outputs are low, every mask register reads 32'hFFFF_FFFF, every pending register reads 0 and every line control register reads 0.
- R2: Register offsets within a bank are: pending 0x00, mask 0x04, IRQ code 0x10, FIQ code 0x14, control 0x18, line control 0x1C+4n, software trigger 0x9C. The bank is addr[8+] and the offset is addr[7:0]. Codes and control exist only in bank 0. Unmapped offsets, the control register and the trigger register read 0. Read data appears on rdata_o one cycle after the strobe.
- R3: A line control word holds the priority in [6:2], level sensitivity in [1] (1 = level) and FIQ steering in [0]. Higher bits are dropped on write and read back as 0.
- R4: An edge line becomes pending when its input goes from 0 to 1. It stays pending after the input falls.
- R5: A level line becomes pending when its input rises and is cleared in the cycle its input falls.
- R6: A write to the pending register ANDs the pending bits with the data. Level lines whose input is high keep their bit.
- R7: Among the pending, unmasked lines of a class (steer 0 = IRQ, 1 = FIQ), the lowest priority value wins. A tie goes to the highest line number, where line = bank*32 + bit.
- R8: Each class has an agreement flag, set at reset. While the flag is set and a line is eligible, the next clock latches the winner into the code register, clears the flag and raises the output. Output and code then hold.
- R9: Writing 1 to control bit 0 (IRQ) or bit 1 (FIQ) lowers that output at the next clock and sets its flag. Arbitration then resumes, so an eligible line raises the output again one cycle later.
- R10: Reading a code in bank 0 clears the pending bit of the reported line if that line is edge sensitive. Level lines and reads from other banks clear nothing.
- R11: A write to 0x9C takes the lowest set data bit and makes that line of the addressed bank pending. For an edge line this happens only while its input is low.
- R12: A masked line is never eligible. A mask write takes effect on arbitration in the following cycle.
- R13: When a line's pending bit is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | NUM_BANKS*32 | Interrupt request lines |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8+BANK_W | Byte address: bank and offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | IRQ class output |
| fiq_o | output | 1 | FIQ class output |

## Verification
A line's pending bit can be set and cleared in the same cycle. The set comes from an input rise, and the clear comes from a pending-register write or a code-read acknowledge. The bench provokes this by raising an edge line on the same clock as a write of zero to the pending register, then reads the register back and requires the bit to be set. It also checks that a renew write drops the output for exactly one cycle while an eligible line is still present. Randomised trials of priorities, steering and masks then compare both sorted codes against a model of the arbitration rule.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LINES_PER_BANK = 32;
  localparam int PRIO_W         = 5;

  localparam logic [7:0] OFF_PEND   = 8'h00;
  localparam logic [7:0] OFF_MASK   = 8'h04;
  localparam logic [7:0] OFF_CODE_I = 8'h10;
  localparam logic [7:0] OFF_CODE_F = 8'h14;
  localparam logic [7:0] OFF_CTRL   = 8'h18;
  localparam logic [7:0] OFF_CFG_LO = 8'h1C;
  localparam logic [7:0] OFF_CFG_HI = 8'h98;
  localparam logic [7:0] OFF_SWTRIG = 8'h9C;

  typedef enum logic {CLS_IRQ = 1'b0, CLS_FIQ = 1'b1} irq_class_e;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
(
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [LINES_PER_BANK-1:0]             lines_i,
  input  logic                                  pend_wr_i,
  input  logic                                  mask_wr_i,
  input  logic                                  cfg_wr_i,
  input  logic [4:0]                            cfg_idx_i,
  input  logic                                  sw_wr_i,
  input  logic [31:0]                           wdata_i,
  input  logic [LINES_PER_BANK-1:0]             ack_i,
  output logic [LINES_PER_BANK-1:0]             pend_o,
  output logic [LINES_PER_BANK-1:0]             mask_o,
  output logic [LINES_PER_BANK-1:0]             lvl_o,
  output logic [LINES_PER_BANK-1:0]             steer_o,
  output logic [LINES_PER_BANK-1:0][PRIO_W-1:0] prio_o
);
  logic [LINES_PER_BANK-1:0] in_q, pend_q, mask_q, lvl_q, steer_q;
  logic [LINES_PER_BANK-1:0][PRIO_W-1:0] prio_q;
  logic [LINES_PER_BANK-1:0] rise, fall, wr_clr, ack_clr, sw_bit, sw_set, pend_d;

  always_comb begin
    rise    = lines_i & ~in_q;
    fall    = ~lines_i & in_q & lvl_q;
    wr_clr  = pend_wr_i ? ~(wdata_i | (in_q & lvl_q)) : '0;
    ack_clr = ack_i & ~lvl_q;
    sw_bit  = wdata_i & (~wdata_i + 32'd1);   // isolate lowest set bit
    sw_set  = sw_wr_i ? (sw_bit & (lvl_q | ~in_q)) : '0;
    // set sources win over every clear source
    pend_d  = (pend_q & ~fall & ~wr_clr & ~ack_clr) | rise | sw_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q    <= '0;
      pend_q  <= '0;
      mask_q  <= '1;
      lvl_q   <= '0;
      steer_q <= '0;
      prio_q  <= '0;
    end else begin
      in_q   <= lines_i;
      pend_q <= pend_d;
      if (mask_wr_i) mask_q <= wdata_i;
      if (cfg_wr_i) begin
        prio_q[cfg_idx_i]  <= wdata_i[PRIO_W+1:2];
        lvl_q[cfg_idx_i]   <= wdata_i[1];
        steer_q[cfg_idx_i] <= wdata_i[0];
      end
    end
  end

  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign lvl_o   = lvl_q;
  assign steer_o = steer_q;
  assign prio_o  = prio_q;

  // a held-high level line survives any clear source
  p_level_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_q & lvl_q & in_q & lines_i)) |=>
      (($past(pend_q & lvl_q & in_q & lines_i) & ~pend_q) == '0));

  p_level_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_wr_i && |(lvl_q & in_q & ~lines_i)) |=>
      ((pend_q & $past(lvl_q & in_q & ~lines_i)) == '0));

  p_rise_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(lines_i & ~in_q)) |=> (($past(lines_i & ~in_q) & ~pend_q) == '0));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]             elig_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  output logic                     valid_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [PRIO_W-1:0] best_p;

  // ascending scan with <= so ties resolve to the highest index
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best_p  = '1;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!valid_o || prio_i[i] <= best_p)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        best_p  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/intc_class_ctl.sv
module intc_class_ctl #(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             renew_i,
  input  logic             any_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             out_o,
  output logic [IDX_W-1:0] code_o
);
  logic             agr_q, out_q;
  logic [IDX_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      agr_q  <= 1'b1;
      out_q  <= 1'b0;
      code_q <= '0;
    end else if (renew_i) begin
      agr_q <= 1'b1;
      out_q <= 1'b0;
    end else if (agr_q && any_i) begin
      agr_q  <= 1'b0;
      out_q  <= 1'b1;
      code_q <= idx_i;
    end
  end

  assign out_o  = out_q;
  assign code_o = code_q;

  p_renew_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    renew_i |=> !out_q);

  p_raise_needs_agr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q) |-> ($past(agr_q) && $past(any_i)));

  p_code_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q && !renew_i) |=> (out_q && $stable(code_q)));
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import intc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = 8 + BANK_W,
  localparam int NLINES   = NUM_BANKS * LINES_PER_BANK
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] lines_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int IDX_W = $clog2(NLINES);

  logic [BANK_W-1:0] bank_sel;
  logic [7:0]        off;
  logic              bank_ok, wr, rd, cfg_hit, ctrl_wr, ack_en, ack_cls;
  logic [4:0]        cfg_idx;

  logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] pend_all, mask_all, lvl_all, steer_all;
  logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0][PRIO_W-1:0] prio_all;
  logic [NLINES-1:0]                    pend_flat, mask_flat, steer_flat;
  logic [NLINES-1:0][PRIO_W-1:0]        prio_flat;
  logic [1:0][NLINES-1:0]               elig;
  logic [1:0]                           arb_vld, renew, cls_out;
  logic [1:0][IDX_W-1:0]                arb_idx, code;
  logic [IDX_W-1:0]                     ack_line;
  logic [31:0]                          rd_val, rdata_q;

  assign bank_sel = addr_i[ADDR_W-1:8];
  assign off      = addr_i[7:0];
  assign bank_ok  = int'(bank_sel) < NUM_BANKS;
  assign wr       = req_i && we_i && bank_ok;
  assign rd       = req_i && !we_i;
  assign cfg_hit  = (off >= OFF_CFG_LO) && (off <= OFF_CFG_HI) && (off[1:0] == 2'b00);
  assign cfg_idx  = 5'((off - OFF_CFG_LO) >> 2);
  assign ctrl_wr  = wr && (bank_sel == '0) && (off == OFF_CTRL);
  assign ack_en   = rd && (bank_sel == '0) && ((off == OFF_CODE_I) || (off == OFF_CODE_F));
  assign ack_cls  = (off == OFF_CODE_F);
  assign ack_line = code[ack_cls];
  assign renew    = ctrl_wr ? wdata_i[1:0] : 2'b00;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic                      sel;
    logic [LINES_PER_BANK-1:0] ack_vec;

    assign sel     = wr && (int'(bank_sel) == b);
    assign ack_vec = (ack_en && (int'(ack_line >> 5) == b))
                     ? (LINES_PER_BANK'(1) << ack_line[4:0]) : '0;

    intc_bank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lines_i   (lines_i[b*LINES_PER_BANK +: LINES_PER_BANK]),
      .pend_wr_i (sel && (off == OFF_PEND)),
      .mask_wr_i (sel && (off == OFF_MASK)),
      .cfg_wr_i  (sel && cfg_hit),
      .cfg_idx_i (cfg_idx),
      .sw_wr_i   (sel && (off == OFF_SWTRIG)),
      .wdata_i   (wdata_i),
      .ack_i     (ack_vec),
      .pend_o    (pend_all[b]),
      .mask_o    (mask_all[b]),
      .lvl_o     (lvl_all[b]),
      .steer_o   (steer_all[b]),
      .prio_o    (prio_all[b])
    );
  end

  assign pend_flat  = pend_all;
  assign mask_flat  = mask_all;
  assign steer_flat = steer_all;
  assign prio_flat  = prio_all;

  for (genvar c = 0; c < 2; c++) begin : g_cls
    if (c == int'(CLS_FIQ)) begin : g_f
      assign elig[c] = pend_flat & ~mask_flat & steer_flat;
    end else begin : g_i
      assign elig[c] = pend_flat & ~mask_flat & ~steer_flat;
    end

    intc_arbiter #(.N(NLINES), .IDX_W(IDX_W)) u_arb (
      .elig_i  (elig[c]),
      .prio_i  (prio_flat),
      .valid_o (arb_vld[c]),
      .idx_o   (arb_idx[c])
    );

    intc_class_ctl #(.IDX_W(IDX_W)) u_ctl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .renew_i (renew[c]),
      .any_i   (arb_vld[c]),
      .idx_i   (arb_idx[c]),
      .out_o   (cls_out[c]),
      .code_o  (code[c])
    );

    p_pick_eligible_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arb_vld[c] |-> elig[c][arb_idx[c]]);
    p_masked_never_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arb_vld[c] |-> !mask_flat[arb_idx[c]]);
  end

  always_comb begin
    rd_val = '0;
    if (bank_ok) begin
      if (off == OFF_PEND)      rd_val = pend_all[bank_sel];
      else if (off == OFF_MASK) rd_val = mask_all[bank_sel];
      else if (off == OFF_CODE_I && bank_sel == '0) rd_val = 32'(code[0]);
      else if (off == OFF_CODE_F && bank_sel == '0) rd_val = 32'(code[1]);
      else if (cfg_hit)
        rd_val = 32'({prio_all[bank_sel][cfg_idx], lvl_all[bank_sel][cfg_idx],
                      steer_all[bank_sel][cfg_idx]});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = cls_out[0];
  assign fiq_o   = cls_out[1];
endmodule

// File: tb/irq_ctrl_regs_bench.sv
module irq_ctrl_regs_bench;
  localparam int NB = 2;
  localparam int NL = NB * 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] lines_i = '0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [8:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          irq_o, fiq_o;

  int errors = 0, checks = 0;
  bit done = 0;

  int unsigned m_prio [NL];
  bit          m_steer[NL];
  bit          m_pend [NL];
  bit          m_mask [NL];

  irq_ctrl_regs #(.NUM_BANKS(NB)) u_irq_ctrl_regs (
    .clk_i, .rst_ni, .lines_i, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .fiq_o
  );

  always #4 clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i);
    req_i = 0;
    d = rdata_o;
  endtask

  function automatic int exp_code(bit cls);
    int best = -1;
    for (int i = 0; i < NL; i++)
      if (m_pend[i] && !m_mask[i] && m_steer[i] == cls &&
          (best < 0 || m_prio[i] <= m_prio[best])) best = i;
    return best;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    check("R1 fiq", 32'(fiq_o), 0);
    rd(9'h004, d); check("R1 mask b0", d, 32'hFFFF_FFFF);
    rd(9'h104, d); check("R1 mask b1", d, 32'hFFFF_FFFF);
    rd(9'h000, d); check("R1 pend", d, 0);
    rd(9'h01C, d); check("R1 cfg", d, 0);

    // R3 field packing
    wr(9'h030, 32'hFFFF_FFA7); rd(9'h030, d); check("R3 cfg b0 l5", d, 32'h27);
    wr(9'h198, 32'h7E);        rd(9'h198, d); check("R3 cfg b1 l31", d, 32'h7E);

    // R2 unmapped / bank-0-only
    rd(9'h008, d); check("R2 unmapped", d, 0);
    rd(9'h110, d); check("R2 code in b1", d, 0);
    rd(9'h018, d); check("R2 ctrl read", d, 0);
    rd(9'h09C, d); check("R2 trig read", d, 0);

    // R4 edge line 3
    @(negedge clk_i); lines_i[3] = 1;
    @(negedge clk_i); lines_i[3] = 0;
    rd(9'h000, d); check("R4 edge held", d, 32'h8);
    wr(9'h000, 0); rd(9'h000, d); check("R6 edge cleared", d, 0);

    // R5/R6 level line 4
    wr(9'h02C, 32'h2);
    @(negedge clk_i); lines_i[4] = 1;
    rd(9'h000, d); check("R5 level set", d, 32'h10);
    wr(9'h000, 0); rd(9'h000, d); check("R6 level kept", d, 32'h10);
    @(negedge clk_i); lines_i[4] = 0;
    rd(9'h000, d); check("R5 level fall", d, 0);

    // R8 agreement and latch
    wr(9'h004, ~32'h18);
    check("R8 idle", 32'(irq_o), 0);
    @(negedge clk_i); lines_i[3] = 1;
    @(negedge clk_i); check("R8 not yet", 32'(irq_o), 0);
    @(negedge clk_i); check("R8 raised", 32'(irq_o), 1);
    rd(9'h110, d); check("R10 b1 read", d, 0);
    rd(9'h000, d); check("R10 no ack b1", d, 32'h8);
    rd(9'h010, d); check("R8 code", d, 3);
    rd(9'h000, d); check("R10 edge acked", d, 0);
    check("R8 held", 32'(irq_o), 1);
    wr(9'h018, 1); check("R9 drop", 32'(irq_o), 0);
    @(negedge clk_i); check("R9 none eligible", 32'(irq_o), 0);
    lines_i[3] = 0;

    // R10 level not acked, R9 re-assert
    @(negedge clk_i); lines_i[4] = 1;
    @(negedge clk_i); @(negedge clk_i); check("R8 level raise", 32'(irq_o), 1);
    rd(9'h010, d); check("R8 code level", d, 4);
    rd(9'h000, d); check("R10 level kept", d, 32'h10);
    wr(9'h018, 1); check("R9 drop again", 32'(irq_o), 0);
    @(negedge clk_i); check("R9 reassert", 32'(irq_o), 1);
    lines_i[4] = 0;

    // R13 set beats write-clear in the same cycle
    @(negedge clk_i);
    lines_i[3] = 1; req_i = 1; we_i = 1; addr_i = 9'h000; wdata_i = 0;
    @(negedge clk_i); req_i = 0; we_i = 0;
    rd(9'h000, d); check("R13 set wins", d, 32'h8);

    // R11 software trigger
    wr(9'h000, 0);
    wr(9'h09C, 32'h180); rd(9'h000, d); check("R11 lowest bit", d, 32'h80);
    wr(9'h09C, 32'h8);   rd(9'h000, d); check("R11 edge input high", d, 32'h80);
    wr(9'h09C, 32'h10);  rd(9'h000, d); check("R11 level", d, 32'h90);
    wr(9'h000, 0);       rd(9'h000, d); check("R6 clear all", d, 0);

    // R12 mask
    wr(9'h09C, 32'h80);
    wr(9'h018, 1); @(negedge clk_i); check("R12 masked", 32'(irq_o), 0);
    wr(9'h004, ~32'h98); check("R12 not same cycle", 32'(irq_o), 0);
    @(negedge clk_i); check("R12 unmasked", 32'(irq_o), 1);
    rd(9'h010, d); check("R12 code", d, 7);

    // R7 FIQ steering, bank 1 line 9 -> line 41
    wr(9'h140, 32'h0B); wr(9'h104, ~32'h200); wr(9'h19C, 32'h200);
    wr(9'h018, 2); @(negedge clk_i); check("R7 fiq", 32'(fiq_o), 1);
    rd(9'h014, d); check("R7 fiq code", d, 41);
    lines_i = '0;
    @(negedge clk_i);

    // R7 randomized arbitration
    for (int t = 0; t < 20; t++) begin
      for (int n = 0; n < NL; n++) begin
        m_prio[n]  = $urandom % 4;
        m_steer[n] = $urandom % 2;
        m_pend[n]  = 0;
        wr(9'((n / 32) * 256 + 28 + 4 * (n % 32)), (m_prio[n] << 2) | 2 | 32'(m_steer[n]));
      end
      for (int b = 0; b < NB; b++) begin
        logic [31:0] mk;
        mk = $urandom & $urandom;
        for (int i = 0; i < 32; i++) m_mask[b * 32 + i] = mk[i];
        wr(9'(b * 256), 0);
        wr(9'(b * 256 + 4), mk);
      end
      for (int k = 0; k < 5; k++) begin
        int ln;
        ln = $urandom % NL;
        m_pend[ln] = 1;
        wr(9'((ln / 32) * 256 + 'h9C), 32'd1 << (ln % 32));
      end
      wr(9'h018, 3); @(negedge clk_i);
      for (int c = 0; c < 2; c++) begin
        int e;
        e = exp_code(c[0]);
        check("R7 out", 32'(c ? fiq_o : irq_o), 32'(e >= 0));
        if (e >= 0) begin
          rd(c ? 9'h014 : 9'h010, d);
          check("R7 code", d, 32'(e));
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule